// File: doc/BRIEF.md
# Static RAM Cycle Controller with Byte Lanes

This block sits between an on-chip host and an external asynchronous static RAM of 256K words by 16 bits. The host presents one request at a time on a valid/ready handshake: a read or write flag, an 18-bit word address, 16 bits of write data and a two-bit lane mask. The controller turns that request into a sequence of pin states. It asserts both chip selects, which have opposite polarity, and the per-byte strobes. For a write it pulses write enable while driving data. For a read it holds output enable low and samples the returned word.

Every analog timing of the memory is met by counting clock cycles. The read window, write setup, write pulse and write recovery lengths are parameters, each rounded up from its nanosecond limit. The defaults suit a 100 MHz clock. The shared data bus is split at this boundary into an outgoing word, a driver enable and an incoming word. A pad cell outside the block merges them onto the bidirectional pins.

A request with an empty lane mask is consumed without any bus activity. After every read the controller inserts one quiet cycle, so that the memory's output drivers have released the bus before the controller's own driver can turn on.

Top module: `sram_ctl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the pins are idle: cs1_n=1, cs2=0, we_n=1, oe_n=1, lb_n=1, ub_n=1 and dq_oe=0. Also req_ready=1 and rsp_valid=0.
- R2: The memory is selected (cs1_n=0 and cs2=1) only during an accepted request's bus cycle. Throughout that cycle mem_addr equals the request address and does not change.
- R3: During a bus cycle lb_n is low exactly when mask bit 0 is set (lower byte, data bits 7:0), and ub_n is low exactly when mask bit 1 is set (upper byte, data bits 15:8). Both strobes are high whenever the chip is not selected.
- R4: A read holds oe_n low for RD_CYCLES cycles and samples mem_dq_in at the clock edge that ends that window. rsp_valid is then high for exactly one cycle, RD_CYCLES clock edges after the accepting edge.
- R5: A write keeps the chip selected with we_n high for WR_SETUP cycles. It then holds we_n low for WR_PULSE cycles, then keeps the chip selected with we_n high for WR_RECOV cycles. we_n never falls unless the chip and a byte strobe were already active in the previous cycle.
- R6: dq_oe is high only while we_n is low and oe_n is high. While dq_oe is high, mem_dq_out carries the request's write data.
- R7: After every read, req_ready stays low for one more cycle, the cycle in which rsp_valid is high. dq_oe never rises less than two cycles after oe_n was low.
- R8: req_ready is low from the accepting edge until the bus cycle has ended. A read keeps it low for RD_CYCLES+1 cycles, a write for WR_SETUP+WR_PULSE+WR_RECOV cycles.
- R9: A request with mask 2'b00 is accepted, produces no bus cycle and no response, and leaves memory contents unchanged.
- R10: In rsp_rdata, a lane whose mask bit is clear reads as zero. Enabled lanes return the memory word, so a partial write followed by a read shows merged bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, can accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address pins |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data driver |
| mem_dq_in | input | 16 | Data from the memory |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |

## Verification
The embedded properties watch several rules on every cycle:
- the address stays constant while the chip is selected;
- write enable only falls after the selects are already active;
- the data driver stays inside the write-enable window and never overlaps output enable;
- the gap before the driver turns on after a read;
- the single-cycle response pulse;
- the empty-mask no-operation.

The exact cycle counts of each phase, the latency of the read response, the lane zeroing of returned data and the merging of partial writes can only be shown by the bench. It runs operation sequences against a small behavioural memory model and reads the results back through the normal interface.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_READ   = 3'd1,
        PH_TURN   = 3'd2,
        PH_WSETUP = 3'd3,
        PH_WPULSE = 3'd4,
        PH_WRECOV = 3'd5
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
    } req_t;

    typedef struct packed {
        logic             cs1_n;
        logic             cs2;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] lane_n;
        logic             dq_oe;
    } pins_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] lane_keep(input logic [DATA_W-1:0] d,
                                                    input logic [LANES-1:0]  m);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[i*LANE_W +: LANE_W] = m[i] ? d[i*LANE_W +: LANE_W] : '0;
        end
        return r;
    endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYCLES = 6,
    parameter int WR_SETUP  = 1,
    parameter int WR_PULSE  = 5,
    parameter int WR_RECOV  = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   start_wr,
    output phase_e phase,
    output logic   idle,
    output logic   rd_done
);

    localparam int MAXC  = max4(RD_CYCLES, WR_SETUP, WR_PULSE, WR_RECOV);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYCLES - 1);
    localparam logic [CNT_W-1:0] SU_LOAD = CNT_W'(WR_SETUP - 1);
    localparam logic [CNT_W-1:0] PW_LOAD = CNT_W'(WR_PULSE - 1);
    localparam logic [CNT_W-1:0] RC_LOAD = CNT_W'((WR_RECOV > 0) ? WR_RECOV - 1 : 0);
    localparam bit HAS_RECOV = (WR_RECOV > 0);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last    = (cnt_q == '0);
    assign phase   = ph_q;
    assign idle    = (ph_q == PH_IDLE);
    assign rd_done = (ph_q == PH_READ) && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        if (start_wr) begin
                            ph_q  <= PH_WSETUP;
                            cnt_q <= SU_LOAD;
                        end else begin
                            ph_q  <= PH_READ;
                            cnt_q <= RD_LOAD;
                        end
                    end
                end
                PH_READ: begin
                    if (last) ph_q <= PH_TURN;
                    else      cnt_q <= cnt_q - 1'b1;
                end
                PH_TURN: ph_q <= PH_IDLE;
                PH_WSETUP: begin
                    if (last) begin
                        ph_q  <= PH_WPULSE;
                        cnt_q <= PW_LOAD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_WPULSE: begin
                    if (last) begin
                        if (HAS_RECOV) begin
                            ph_q  <= PH_WRECOV;
                            cnt_q <= RC_LOAD;
                        end else begin
                            ph_q <= PH_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_WRECOV: begin
                    if (last) ph_q <= PH_IDLE;
                    else      cnt_q <= cnt_q - 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R7
    turn_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> (ph_q == PH_TURN));

    // R8
    start_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (start && idle) |=> !idle);

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
    import sram_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  logic [LANES-1:0] mask,
    input  logic [ADDR_W-1:0] addr,
    output pins_t            pins
);

    logic sel;

    assign sel = (phase == PH_READ)   || (phase == PH_WSETUP) ||
                 (phase == PH_WPULSE) || (phase == PH_WRECOV);

    always_comb begin
        pins.cs1_n = !sel;
        pins.cs2   = sel;
        pins.oe_n  = (phase != PH_READ);
        pins.we_n  = (phase != PH_WPULSE);
        pins.dq_oe = (phase == PH_WPULSE);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign pins.lane_n[g] = !(sel && mask[g]);
    end

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pins.cs1_n && $past(!pins.cs1_n)) |-> $stable(addr));

    // R3
    lane_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pins.cs1_n |-> (&pins.lane_n));

    // R5
    we_after_sel_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pins.we_n) |-> $past(!pins.cs1_n && pins.cs2 && !(&pins.lane_n)));

    // R6
    drive_window_chk: assert property (@(posedge clk) disable iff (rst)
        pins.dq_oe |-> (!pins.we_n && pins.oe_n));

    // R7
    turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.dq_oe) |-> ($past(pins.oe_n) && $past(pins.oe_n, 2)));

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap
    import sram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= lane_keep(dq_in, mask);
        end
    end

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYCLES = 6,
    parameter int WR_SETUP  = 1,
    parameter int WR_PULSE  = 5,
    parameter int WR_RECOV  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n
);

    req_t   req_q;
    phase_e phase;
    pins_t  pins;
    logic   idle, accept, start, rd_done;

    assign req_ready = idle;
    assign accept    = req_valid && idle;
    assign start     = accept && (req_mask != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (start) begin
            req_q.wr    <= req_write;
            req_q.addr  <= req_addr;
            req_q.wdata <= req_wdata;
            req_q.mask  <= req_mask;
        end
    end

    sram_ctl_seq #(
        .RD_CYCLES (RD_CYCLES),
        .WR_SETUP  (WR_SETUP),
        .WR_PULSE  (WR_PULSE),
        .WR_RECOV  (WR_RECOV)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .start_wr (req_write),
        .phase    (phase),
        .idle     (idle),
        .rd_done  (rd_done)
    );

    sram_ctl_pins u_pins (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .mask  (req_q.mask),
        .addr  (req_q.addr),
        .pins  (pins)
    );

    sram_ctl_rdcap u_rdcap (
        .clk       (clk),
        .rst       (rst),
        .capture   (rd_done),
        .mask      (req_q.mask),
        .dq_in     (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_addr   = req_q.addr;
    assign mem_dq_out = req_q.wdata;
    assign mem_dq_oe  = pins.dq_oe;
    assign mem_cs1_n  = pins.cs1_n;
    assign mem_cs2    = pins.cs2;
    assign mem_we_n   = pins.we_n;
    assign mem_oe_n   = pins.oe_n;
    assign mem_lb_n   = pins.lane_n[0];
    assign mem_ub_n   = pins.lane_n[1];

    // R9
    noop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (req_mask == '0)) |=> (mem_cs1_n && req_ready && !rsp_valid));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs1_n) |-> !req_ready);

endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

    localparam int RD  = 6;
    localparam int SU  = 1;
    localparam int PW  = 5;
    localparam int RC  = 1;

    typedef struct packed {
        logic        wr;
        logic [17:0] a;
        logic [15:0] d;
        logic [1:0]  m;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 18'h00005, 16'h1234, 2'b11, 16'h0000},
        '{1'b0, 18'h00005, 16'h0000, 2'b11, 16'h1234},
        '{1'b1, 18'h00005, 16'hABCD, 2'b01, 16'h0000},
        '{1'b0, 18'h00005, 16'h0000, 2'b11, 16'h12CD},
        '{1'b1, 18'h3FFC7, 16'h5AA5, 2'b10, 16'h0000},
        '{1'b0, 18'h3FFC7, 16'h0000, 2'b11, 16'h5A00},
        '{1'b0, 18'h00005, 16'h0000, 2'b10, 16'h1200},
        '{1'b0, 18'h00005, 16'h0000, 2'b01, 16'h00CD}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic [15:0] mem_dq_out, mem_dq_in;
    logic        mem_dq_oe, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;

    int checks = 0;
    int errors = 0;
    int drv_err = 0;
    int turn_err = 0;
    int since_oe = 10;

    always #2.5 clk = ~clk;

    sram_ctl #(.RD_CYCLES(RD), .WR_SETUP(SU), .WR_PULSE(PW), .WR_RECOV(RC)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
    );

    // behavioural memory model, 64 words, aliased on the low address bits
    logic [15:0] mem [64];
    logic        model_sel;
    assign model_sel = !mem_cs1_n && mem_cs2;

    initial for (int i = 0; i < 64; i++) mem[i] = 16'h0000;

    always @(posedge clk) begin
        if (model_sel && !mem_we_n && mem_dq_oe) begin
            if (!mem_lb_n) mem[mem_addr[5:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) mem[mem_addr[5:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    always_comb begin
        mem_dq_in[7:0]  = (model_sel && mem_we_n && !mem_oe_n && !mem_lb_n) ? mem[mem_addr[5:0]][7:0]  : 8'hA5;
        mem_dq_in[15:8] = (model_sel && mem_we_n && !mem_oe_n && !mem_ub_n) ? mem[mem_addr[5:0]][15:8] : 8'hA5;
    end

    // pin monitors for R6 and R7
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && (mem_we_n || !mem_oe_n)) drv_err++;
            if (mem_dq_oe && since_oe < 2) turn_err++;
            if (!mem_oe_n) since_oe = 0;
            else if (since_oe < 10) since_oe++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic do_op(input logic wr, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] m,
                         output logic [15:0] rd, output int lat, output int first_we,
                         output int we_cnt, output int sel_cnt, output int busy,
                         output int lane_err, output int addr_err, output int data_err,
                         output int got);
        int  k;
        bit  done;
        rd = '0; lat = -1; first_we = -1; we_cnt = 0; sel_cnt = 0; busy = 0;
        lane_err = 0; addr_err = 0; data_err = 0; got = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0; done = 1'b0;
        while (!done && k < 64) begin
            if (!mem_cs1_n && mem_cs2) begin
                sel_cnt++;
                if (mem_lb_n !== ~m[0] || mem_ub_n !== ~m[1]) lane_err++;
                if (mem_addr !== a) addr_err++;
            end
            if (!mem_we_n) begin
                if (we_cnt == 0) first_we = k;
                we_cnt++;
                if (mem_dq_out !== d) data_err++;
            end
            if (rsp_valid) begin
                got++;
                lat = k;
                rd = rsp_rdata;
            end
            if (!req_ready) busy++;
            if (req_ready) done = 1'b1;
            else begin
                @(negedge clk);
                k++;
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int lat, fwe, wec, selc, busy, le, ae, de, got;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 pins in reset", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n,
                                 mem_dq_oe, req_ready, rsp_valid}, 9'b1_0_1_1_1_1_0_1_0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pins after reset", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n,
                                    mem_dq_oe, req_ready, rsp_valid}, 9'b1_0_1_1_1_1_0_1_0);

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i].wr, VEC[i].a, VEC[i].d, VEC[i].m, rd, lat, fwe, wec, selc, busy, le, ae, de, got);
            chk("R2 address held", ae, 0);
            chk("R3 lane strobes", le, 0);
            if (VEC[i].wr) begin
                chk("R5 selected cycles", selc, SU + PW + RC);
                chk("R5 we_n low cycles", wec, PW);
                chk("R5 setup before we_n", fwe, SU);
                chk("R6 write data on bus", de, 0);
                chk("R8 write busy cycles", busy, SU + PW + RC);
                chk("R4 no response to write", got, 0);
            end else begin
                chk("R4 read latency", lat, RD);
                chk("R4 single response", got, 1);
                chk("R2 read selected cycles", selc, RD);
                chk("R7 R8 read busy cycles", busy, RD + 1);
                chk("R10 read data", rd, VEC[i].exp);
            end
        end

        // R9: empty mask write is a no-operation
        do_op(1'b1, 18'h00005, 16'hFFFF, 2'b00, rd, lat, fwe, wec, selc, busy, le, ae, de, got);
        chk("R9 no selection", selc, 0);
        chk("R9 no we pulse", wec, 0);
        chk("R9 no busy", busy, 0);
        do_op(1'b0, 18'h00005, 16'h0000, 2'b00, rd, lat, fwe, wec, selc, busy, le, ae, de, got);
        chk("R9 no response", got, 0);
        do_op(1'b0, 18'h00005, 16'h0000, 2'b11, rd, lat, fwe, wec, selc, busy, le, ae, de, got);
        chk("R9 memory unchanged", rd, 16'h12CD);

        // R7: write right after a read, then check monitors
        do_op(1'b1, 18'h00009, 16'hC3C3, 2'b11, rd, lat, fwe, wec, selc, busy, le, ae, de, got);
        do_op(1'b0, 18'h00009, 16'h0000, 2'b11, rd, lat, fwe, wec, selc, busy, le, ae, de, got);
        chk("R10 full word round trip", rd, 16'hC3C3);
        chk("R6 driver outside write window", drv_err, 0);
        chk("R7 driver too soon after read", turn_err, 0);

        summary();
        $finish;
    end

endmodule